// File: doc/BRIEF.md
# Power-Fail Transfer Controller for Shadowed RAM

This controller sequences data transfers between a RAM and its nonvolatile shadow copy. It takes two comparator flags from the supply monitor. One says the supply is above the switch threshold, where the part may operate. The other says the supply has dropped below the lower reset threshold. Each flag passes through a two-flop synchronizer and a hold filter. The controller acts on a new level only after it has been stable for `FILT_CYC` cycles. Software asks for a shadow save (store) or a shadow reload (recall) with a single-cycle request pulse.

While the supply is low, stores cannot start and the RAM is reported busy. A sticky flag records whether the supply reached the reset level during an outage. When the supply comes back above the switch threshold, a reload runs only if that flag is set. A shallow brown-out therefore leaves the RAM contents as they were. Each transfer holds the busy flag for a fixed number of clock cycles set by a parameter. A request that arrives while busy is dropped. The standby-allowed output stays low while any transfer is running, even when the chip is deselected.

Top module: `pwr_xfer_ctrl`

## Requirements
- R1: While reset is asserted, `busy_o` is 1 and both `recall_act_o` and `store_act_o` are 0.
- R2: If the filtered below-reset flag was seen since the last automatic reload, the supply's return above the switch threshold starts a reload. `recall_act_o` then stays high for exactly `RESTORE_CYC` cycles, after which `busy_o` is 0.
- R3: If the supply dips below the switch threshold but never reaches the reset level, its return brings the controller back to idle (`busy_o` = 0) and no reload runs.
- R4: While the filtered supply-ok flag is 0, `busy_o` is 1, and a request pulse starts neither a store nor a recall.
- R5: A request with `req_store_i` = 1 in idle starts a store, and `store_act_o` stays high for exactly `STORE_CYC` cycles.
- R6: A request with `req_store_i` = 0 in idle starts a recall, and `recall_act_o` stays high for exactly `RESTORE_CYC` cycles.
- R7: A request that arrives during a transfer neither lengthens it nor starts another transfer after it ends.
- R8: Loss of supply during a store aborts it. `store_act_o` falls and `busy_o` stays 1.
- R9: `standby_ok_o` is 1 only when `chip_sel_i` is 0 and no store or recall is active.
- R10: A threshold input change that lasts fewer than `FILT_CYC` cycles has no effect on the outputs.
- R11: `recall_act_o` and `store_act_o` are never 1 together, and either one implies `busy_o` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| above_sw_i | input | 1 | Comparator: supply above switch threshold (asynchronous) |
| below_rst_i | input | 1 | Comparator: supply below reset threshold (asynchronous) |
| req_valid_i | input | 1 | One-cycle transfer request pulse |
| req_store_i | input | 1 | Request kind: 1 = store to shadow, 0 = recall from shadow |
| chip_sel_i | input | 1 | RAM selected by host |
| recall_act_o | output | 1 | Reload from shadow in progress |
| store_act_o | output | 1 | Save to shadow in progress |
| busy_o | output | 1 | RAM access blocked |
| standby_ok_o | output | 1 | Standby entry permitted |

## Verification
The bench covers two kinds of power-up. After a deep outage a reload must run. A design that ignores the sticky flag would skip it, or would reload after every brown-out. The bench counts each strobe's high time cycle by cycle. An off-by-one timer load shows up as a transfer one cycle short or long. A request placed in the middle of a transfer catches a design that restarts the timer or queues the request. The bench also checks that a store is aborted when the supply fails. It drives threshold glitches shorter than the filter window, which would otherwise raise `busy_o`. Randomly selected requests and chip-select levels check the standby gating.

// File: rtl/pwr_xfer_pkg.sv
package pwr_xfer_pkg;
  typedef enum logic [1:0] {
    ST_LOW    = 2'd0,
    ST_RECALL = 2'd1,
    ST_READY  = 2'd2,
    ST_STORE  = 2'd3
  } xfer_state_t;
endpackage

// File: rtl/pwr_level_filter.sv
module pwr_level_filter #(
  parameter int   FILT_CYC = 4,
  parameter logic RST_VAL  = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic level_o
);
  localparam int CW = $clog2(FILT_CYC + 1);

  logic          s1_q, s2_q;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          lvl_q, lvl_d;

  always_comb begin
    cnt_d = cnt_q;
    lvl_d = lvl_q;
    if (s2_q == lvl_q) begin
      cnt_d = '0;
    end else if (cnt_q == CW'(FILT_CYC - 1)) begin
      cnt_d = '0;
      lvl_d = s2_q;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q  <= RST_VAL;
      s2_q  <= RST_VAL;
      cnt_q <= '0;
      lvl_q <= RST_VAL;
    end else begin
      s1_q  <= raw_i;
      s2_q  <= s1_q;
      cnt_q <= cnt_d;
      lvl_q <= lvl_d;
    end
  end

  assign level_o = lvl_q;

  // R10: the filtered level only takes a value the synchronizer already held
  a_r10_level_from_sync: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lvl_q) |-> (lvl_q == $past(s2_q)));
endmodule

// File: rtl/pwr_cycle_timer.sv
module pwr_cycle_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         done_o
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  assign cnt_en = load_i || (cnt_q != '0);

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)            cnt_d = load_val_i;
    else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign done_o = (cnt_q == '0);

  // R5 / R6: an unloaded, unfinished count steps down by exactly one
  a_r5_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !done_o) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/pwr_xfer_ctrl.sv
module pwr_xfer_ctrl
  import pwr_xfer_pkg::*;
#(
  parameter int FILT_CYC    = 4,
  parameter int RESTORE_CYC = 5500,
  parameter int STORE_CYC   = 100000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic above_sw_i,
  input  logic below_rst_i,
  input  logic req_valid_i,
  input  logic req_store_i,
  input  logic chip_sel_i,
  output logic recall_act_o,
  output logic store_act_o,
  output logic busy_o,
  output logic standby_ok_o
);
  localparam int          MAX_CYC  = (RESTORE_CYC > STORE_CYC) ? RESTORE_CYC : STORE_CYC;
  localparam int          TW       = $clog2(MAX_CYC + 1);
  localparam logic [1:0]  FLT_RST  = 2'b10;   // [1] below-reset starts set, [0] supply-ok starts clear
  localparam logic [TW-1:0] REC_M1 = TW'(RESTORE_CYC - 1);
  localparam logic [TW-1:0] STO_M1 = TW'(STORE_CYC - 1);

  // reset: asserted asynchronously, released on the clock
  logic rs1_q, rs2_q, rst_l;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end
  assign rst_l = rs2_q;

  // threshold filters
  logic [1:0] raw_flags, flt_flags;
  assign raw_flags = {below_rst_i, above_sw_i};

  for (genvar g = 0; g < 2; g++) begin : g_flt
    pwr_level_filter #(
      .FILT_CYC (FILT_CYC),
      .RST_VAL  (FLT_RST[g])
    ) u_flt (
      .clk     (clk),
      .rst_n   (rst_l),
      .raw_i   (raw_flags[g]),
      .level_o (flt_flags[g])
    );
  end

  logic sup_ok, deep_low;
  assign sup_ok   = flt_flags[0];
  assign deep_low = flt_flags[1];

  // transfer timer
  logic          tmr_load, tmr_done;
  logic [TW-1:0] tmr_val;

  pwr_cycle_timer #(.W(TW)) u_tmr (
    .clk        (clk),
    .rst_n      (rst_l),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .done_o     (tmr_done)
  );

  // control
  xfer_state_t st_q, st_d;
  logic        seen_q, seen_d, clr_seen;

  always_comb begin
    st_d     = st_q;
    tmr_load = 1'b0;
    tmr_val  = REC_M1;
    clr_seen = 1'b0;
    unique case (st_q)
      ST_LOW: begin
        if (sup_ok) begin
          if (seen_q) begin
            st_d     = ST_RECALL;
            tmr_load = 1'b1;
            clr_seen = 1'b1;
          end else begin
            st_d = ST_READY;
          end
        end
      end
      ST_RECALL: begin
        if (!sup_ok)       st_d = ST_LOW;
        else if (tmr_done) st_d = ST_READY;
      end
      ST_READY: begin
        if (!sup_ok) begin
          st_d = ST_LOW;
        end else if (req_valid_i) begin
          tmr_load = 1'b1;
          if (req_store_i) begin
            st_d    = ST_STORE;
            tmr_val = STO_M1;
          end else begin
            st_d = ST_RECALL;
          end
        end
      end
      ST_STORE: begin
        if (!sup_ok)       st_d = ST_LOW;
        else if (tmr_done) st_d = ST_READY;
      end
      default: st_d = ST_LOW;
    endcase
  end

  always_comb begin
    seen_d = seen_q;
    if (deep_low)      seen_d = 1'b1;
    else if (clr_seen) seen_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) begin
      st_q   <= ST_LOW;
      seen_q <= 1'b1;
    end else begin
      st_q   <= st_d;
      seen_q <= seen_d;
    end
  end

  assign recall_act_o = (st_q == ST_RECALL);
  assign store_act_o  = (st_q == ST_STORE);
  assign busy_o       = (st_q != ST_READY);
  assign standby_ok_o = !chip_sel_i && !recall_act_o && !store_act_o;

  // R2: a recorded deep drop triggers the reload on supply return
  a_r2_reload_on_return: assert property (@(posedge clk) disable iff (!rst_l)
    (st_q == ST_LOW && sup_ok && seen_q) |=> recall_act_o);
  // R3: without a deep drop the return goes straight to idle
  a_r3_no_reload: assert property (@(posedge clk) disable iff (!rst_l)
    (st_q == ST_LOW && sup_ok && !seen_q) |=> (!recall_act_o && !busy_o));
  // R4 / R8: a low supply leaves nothing running and the RAM blocked
  a_r4_low_blocks: assert property (@(posedge clk) disable iff (!rst_l)
    !sup_ok |=> (busy_o && !store_act_o && !recall_act_o));
  // R11: strobes exclusive and covered by busy
  a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_l)
    !(recall_act_o && store_act_o));
  a_r11_busy_cover: assert property (@(posedge clk) disable iff (!rst_l)
    (recall_act_o || store_act_o) |-> busy_o);
  // R9: standby never granted mid-transfer
  a_r9_standby_gate: assert property (@(posedge clk) disable iff (!rst_l)
    standby_ok_o |-> (!recall_act_o && !store_act_o && !chip_sel_i));
endmodule

// File: tb/pwr_xfer_ctrl_bench.sv
module pwr_xfer_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int FILT_CYC   = 4;
  localparam int REST_CYC   = 20;
  localparam int STORE_CYC  = 40;

  logic clk = 1'b0;
  logic rst_n, above_sw, below_rst, req_valid, req_store, chip_sel;
  logic recall_act, store_act, busy, standby_ok;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  pwr_xfer_ctrl #(
    .FILT_CYC    (FILT_CYC),
    .RESTORE_CYC (REST_CYC),
    .STORE_CYC   (STORE_CYC)
  ) u_pwr_xfer_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .above_sw_i   (above_sw),
    .below_rst_i  (below_rst),
    .req_valid_i  (req_valid),
    .req_store_i  (req_store),
    .chip_sel_i   (chip_sel),
    .recall_act_o (recall_act),
    .store_act_o  (store_act),
    .busy_o       (busy),
    .standby_ok_o (standby_ok)
  );

  function automatic int exp_len(input bit st);
    return st ? STORE_CYC : REST_CYC;
  endfunction

  task automatic chk(input string rq, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic pulse_req(input bit st);
    req_store = st;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // waits for a strobe, counts its high cycles; optionally fires a request mid-way
  task automatic run_xfer(input bit st, input bit poke, output int len);
    len = 0;
    for (int i = 0; i < 300 && !(st ? store_act : recall_act); i++) @(negedge clk);
    while ((st ? store_act : recall_act) && len < 1000) begin
      if (poke && len == 3) begin
        req_store = $urandom_range(0, 1);
        req_valid = 1'b1;
      end else begin
        req_valid = 1'b0;
      end
      if (len == 1) chk("R9 standby during transfer", standby_ok, 0);
      len++;
      @(negedge clk);
    end
    req_valid = 1'b0;
  endtask

  task automatic idle_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got %0d expected %0d", 0, 1);
    summary();
  end

  initial begin
    int len;
    int saw;
    void'($urandom(32'd1234));
    rst_n = 1'b0; above_sw = 1'b0; below_rst = 1'b1;
    req_valid = 1'b0; req_store = 1'b0; chip_sel = 1'b0;
    idle_n(5);
    chk("R1 busy in reset", busy, 1);
    chk("R1 recall off in reset", recall_act, 0);
    chk("R1 store off in reset", store_act, 0);
    @(negedge clk) rst_n = 1'b1;
    idle_n(3);
    above_sw = 1'b1; below_rst = 1'b0;

    // R2: cold power-up reload
    run_xfer(1'b0, 1'b0, len);
    chk("R2 power-up reload length", len, REST_CYC);
    chk("R2 idle after reload", busy, 0);

    // R5 + R7: store with a request landing mid-way
    pulse_req(1'b1);
    run_xfer(1'b1, 1'b1, len);
    chk("R5 store length", len, exp_len(1'b1));
    chk("R7 store not extended", len, STORE_CYC);
    saw = 0;
    for (int i = 0; i < 5; i++) begin
      if (recall_act || store_act) saw = 1;
      @(negedge clk);
    end
    chk("R7 dropped request not queued", saw, 0);
    chk("R9 standby when idle and deselected", standby_ok, 1);

    // R6: software recall
    pulse_req(1'b0);
    run_xfer(1'b0, 1'b1, len);
    chk("R6 recall length", len, exp_len(1'b0));

    // R9: chip select blocks standby
    chip_sel = 1'b1;
    @(negedge clk);
    chk("R9 selected blocks standby", standby_ok, 0);
    chip_sel = 1'b0;

    // R10: short glitch on the supply flag
    above_sw = 1'b0;
    idle_n(2);
    above_sw = 1'b1;
    saw = 0;
    for (int i = 0; i < 15; i++) begin
      if (busy) saw = 1;
      @(negedge clk);
    end
    chk("R10 glitch ignored", saw, 0);

    // R3 + R4: shallow brown-out
    above_sw = 1'b0;
    idle_n(15);
    chk("R4 busy while low", busy, 1);
    pulse_req(1'b1);
    idle_n(10);
    chk("R4 store inhibited while low", store_act, 0);
    above_sw = 1'b1;
    saw = 0;
    for (int i = 0; i < 40; i++) begin
      if (recall_act) saw = 1;
      @(negedge clk);
    end
    chk("R3 no reload after shallow dip", saw, 0);
    chk("R3 idle after shallow dip", busy, 0);

    // R8: abort store, then deep outage and reload
    pulse_req(1'b1);
    idle_n(10);
    chk("R5 store running", store_act, 1);
    above_sw = 1'b0; below_rst = 1'b1;
    idle_n(15);
    chk("R8 store aborted", store_act, 0);
    chk("R8 busy after abort", busy, 1);
    chk("R11 no recall while low", recall_act, 0);
    idle_n(10);
    below_rst = 1'b0;
    idle_n(15);
    above_sw = 1'b1;
    run_xfer(1'b0, 1'b0, len);
    chk("R2 reload after deep outage", len, REST_CYC);

    // random requests and chip-select levels
    for (int k = 0; k < 16; k++) begin
      bit st;
      bit cs;
      st = 1'($urandom_range(0, 1));
      cs = 1'($urandom_range(0, 1));
      chip_sel = cs;
      idle_n($urandom_range(1, 4));
      pulse_req(st);
      run_xfer(st, 1'($urandom_range(0, 1)), len);
      chk(st ? "R5 random store length" : "R6 random recall length", len, exp_len(st));
      chk("R11 strobes exclusive", int'(recall_act && store_act), 0);
      chk("R9 standby after transfer", standby_ok, int'(!cs));
    end
    summary();
  end
endmodule